// File: doc/BRIEF.md
# Network Function Configuration Header Registers

This block holds the identification and I/O base-address portion of a Type 0 PCI configuration header for a network-controller function. A configuration agent reaches it through a plain register port: a dword index, four byte enables, 32-bit write data, a write strobe and a read strobe. Read data is registered and appears on the clock edge after the read strobe.

Most of the header is constant. The block returns fixed vendor, device, revision and class codes, and a group of housekeeping bytes reads as zero and drops every write. Two fields hold state. The first is a latency timer byte that software may set freely. The second is an I/O base address register that stores only its upper bits. Its low byte is hard-wired, so a sizing write of all ones reveals a 256-byte I/O window with the I/O-space indicator set. Byte enables gate every write lane by lane.

Top module: `netfn_cfg_hdr`

## Requirements
- R1: Dword index 0 reads `{DEVICE_ID, VENDOR_ID}` (device ID in bits 31:16). Writes to it have no effect.
- R2: Dword index 2 reads base class 02h in bits 31:24, sub-class 00h in bits 23:16, programming interface 00h in bits 15:8 and `REVISION` in bits 7:0. Writes to it have no effect.
- R3: At dword index 3, bits 7:0 (cache line size), 23:16 (header type) and 31:24 (self-test) always read zero. Writes to those bytes are discarded.
- R4: The latency timer is dword index 3, bits 15:8. It is read/write, and a write changes it only when byte enable 1 is high.
- R5: Dword index 4 is the I/O base register. Bits 31:8 are read/write per byte lane (enables 3..1). Bits 7:2 and bit 1 always read zero, and bit 0 always reads one, whatever is written.
- R6: After reset the read data output is zero, the latency timer is 00h and the I/O base register reads 00000001h.
- R7: Writing FFFFFFFFh with all byte enables to the I/O base register makes it read FFFFFF01h.
- R8: Every dword index other than 0, 2, 3 and 4 reads zero. Writes there change no state.
- R9: Read data for a read strobe at edge N appears after edge N and holds until the next read strobe. When a read and a write fall in the same cycle, the read returns the contents from before the write.
- R10: A write with all four byte enables low changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_idx | input | IDX_W | Dword index within the header |
| cfg_be | input | 4 | Byte enables for the write, one per byte lane |
| cfg_wdata | input | 32 | Write data |
| cfg_we | input | 1 | Write strobe |
| cfg_re | input | 1 | Read strobe |
| cfg_rdata | output | 32 | Registered read data |

## Verification
A read and a write can land in the same cycle, and a sizing sequence depends on the order between them. The bench drives both strobes together on the I/O base register and on the latency byte. It expects the old contents in that cycle and the new contents on the next read. Partial byte-enable patterns are mixed with these collisions. A behavioural reference model is compared against the read data on every clock, so any leak of a write into the same-cycle read is caught.

// File: rtl/netfn_cfg_pkg.sv
package netfn_cfg_pkg;

    // Dword positions inside the header; software decodes these offsets.
    localparam int unsigned DW_IDENT  = 0;
    localparam int unsigned DW_CLASS  = 2;
    localparam int unsigned DW_MISC   = 3;
    localparam int unsigned DW_IOBASE = 4;

    localparam logic [7:0] CLASS_NETWORK = 8'h02;
    localparam logic [7:0] SUBCLASS_ETH  = 8'h00;
    localparam logic [7:0] PROG_IFACE    = 8'h00;

    typedef struct packed {
        logic ident;
        logic klass;
        logic misc;
        logic iobase;
        logic none;
    } dw_sel_t;

    typedef struct packed {
        logic [7:0] base_class;
        logic [7:0] sub_class;
        logic [7:0] prog_if;
        logic [7:0] rev;
    } class_dw_t;

    typedef struct packed {
        logic [7:0] self_test;
        logic [7:0] hdr_kind;
        logic [7:0] lat_timer;
        logic [7:0] line_size;
    } misc_dw_t;

    // Spread four byte enables into a 32-bit write mask.
    function automatic logic [31:0] lane_mask(input logic [3:0] be);
        logic [31:0] m;
        for (int i = 0; i < 32; i++) begin
            m[i] = be[i / 8];
        end
        return m;
    endfunction

endpackage

// File: rtl/netfn_cfg_decode.sv
module netfn_cfg_decode
    import netfn_cfg_pkg::*;
#(
    parameter int unsigned IDX_W = 6
) (
    input  logic [IDX_W-1:0] idx,
    output dw_sel_t          sel
);
    always_comb begin
        sel        = '0;
        sel.ident  = (idx == IDX_W'(DW_IDENT));
        sel.klass  = (idx == IDX_W'(DW_CLASS));
        sel.misc   = (idx == IDX_W'(DW_MISC));
        sel.iobase = (idx == IDX_W'(DW_IOBASE));
        sel.none   = !(sel.ident || sel.klass || sel.misc || sel.iobase);
    end
endmodule

// File: rtl/netfn_cfg_latency.sv
module netfn_cfg_latency (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] wr_byte,
    output logic [7:0] lat_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            lat_q <= 8'h00;
        end else if (wr_en) begin
            lat_q <= wr_byte;
        end
    end
endmodule

// File: rtl/netfn_cfg_iobase.sv
module netfn_cfg_iobase
    import netfn_cfg_pkg::*;
#(
    parameter int unsigned WIN_BITS = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [3:0]          be,
    input  logic [31:0]         wdata,
    output logic [31:WIN_BITS]  base_q,
    output logic [31:0]         word
);
    logic [31:0] mask;
    logic        unused_low;

    assign mask       = lane_mask(be);
    assign unused_low = ^{wdata[WIN_BITS-1:0], mask[WIN_BITS-1:0]};

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
        end else if (wr_en) begin
            base_q <= (base_q & ~mask[31:WIN_BITS]) | (wdata[31:WIN_BITS] & mask[31:WIN_BITS]);
        end
    end

    // Low bits are fixed: size bits and reserved bit zero, space indicator one.
    generate
        if (WIN_BITS > 1) begin : g_low
            assign word = {base_q, {(WIN_BITS-1){1'b0}}, 1'b1};
        end else begin : g_min
            assign word = {base_q, 1'b1};
        end
    endgenerate
endmodule

// File: rtl/netfn_cfg_rdmux.sv
module netfn_cfg_rdmux
    import netfn_cfg_pkg::*;
#(
    parameter logic [15:0] VENDOR_ID = 16'h1F3A,
    parameter logic [15:0] DEVICE_ID = 16'h0C51,
    parameter logic [7:0]  REVISION  = 8'h07
) (
    input  dw_sel_t     sel,
    input  logic [7:0]  lat,
    input  logic [31:0] iobase_word,
    output logic [31:0] rd
);
    class_dw_t cls;
    misc_dw_t  msc;

    always_comb begin
        cls            = '0;
        cls.base_class = CLASS_NETWORK;
        cls.sub_class  = SUBCLASS_ETH;
        cls.prog_if    = PROG_IFACE;
        cls.rev        = REVISION;

        msc            = '0;
        msc.lat_timer  = lat;

        rd = '0;
        if (sel.ident)  rd = {DEVICE_ID, VENDOR_ID};
        if (sel.klass)  rd = cls;
        if (sel.misc)   rd = msc;
        if (sel.iobase) rd = iobase_word;
    end
endmodule

// File: rtl/netfn_cfg_hdr.sv
module netfn_cfg_hdr
    import netfn_cfg_pkg::*;
#(
    parameter int unsigned IDX_W     = 6,
    parameter int unsigned WIN_BITS  = 8,
    parameter logic [15:0] VENDOR_ID = 16'h1F3A,
    parameter logic [15:0] DEVICE_ID = 16'h0C51,
    parameter logic [7:0]  REVISION  = 8'h07
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] cfg_idx,
    input  logic [3:0]       cfg_be,
    input  logic [31:0]      cfg_wdata,
    input  logic             cfg_we,
    input  logic             cfg_re,
    output logic [31:0]      cfg_rdata
);
    dw_sel_t              sel;
    logic [7:0]           lat_q;
    logic [31:WIN_BITS]   base_q;
    logic [31:0]          iobase_word;
    logic [31:0]          rd_next;
    logic                 unused_base;

    assign unused_base = ^base_q;

    netfn_cfg_decode #(.IDX_W(IDX_W)) u_dec (
        .idx (cfg_idx),
        .sel (sel)
    );

    netfn_cfg_latency u_lat (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cfg_we && sel.misc && cfg_be[1]),
        .wr_byte (cfg_wdata[15:8]),
        .lat_q   (lat_q)
    );

    netfn_cfg_iobase #(.WIN_BITS(WIN_BITS)) u_iob (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (cfg_we && sel.iobase),
        .be     (cfg_be),
        .wdata  (cfg_wdata),
        .base_q (base_q),
        .word   (iobase_word)
    );

    netfn_cfg_rdmux #(
        .VENDOR_ID (VENDOR_ID),
        .DEVICE_ID (DEVICE_ID),
        .REVISION  (REVISION)
    ) u_mux (
        .sel         (sel),
        .lat         (lat_q),
        .iobase_word (iobase_word),
        .rd          (rd_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_rdata <= '0;
        end else if (cfg_re) begin
            cfg_rdata <= rd_next;
        end
    end
endmodule

// File: rtl/netfn_cfg_hdr_chk.sv
module netfn_cfg_hdr_chk #(
    parameter int unsigned IDX_W     = 6,
    parameter logic [15:0] VENDOR_ID = 16'h1F3A,
    parameter logic [15:0] DEVICE_ID = 16'h0C51,
    parameter logic [7:0]  REVISION  = 8'h07
) (
    input logic             clk,
    input logic             rst,
    input logic [IDX_W-1:0] cfg_idx,
    input logic [3:0]       cfg_be,
    input logic             cfg_we,
    input logic             cfg_re,
    input logic [31:0]      cfg_rdata,
    input logic [7:0]       lat_q,
    input logic [31:0]      iobase_word
);
    logic known_idx;
    assign known_idx = (cfg_idx == IDX_W'(0)) || (cfg_idx == IDX_W'(2)) ||
                       (cfg_idx == IDX_W'(3)) || (cfg_idx == IDX_W'(4));

    p_ident_r1: assert property (@(posedge clk) disable iff (rst)
        (cfg_re && cfg_idx == IDX_W'(0)) |=> cfg_rdata == {DEVICE_ID, VENDOR_ID});

    p_class_r2: assert property (@(posedge clk) disable iff (rst)
        (cfg_re && cfg_idx == IDX_W'(2)) |=> cfg_rdata == {8'h02, 16'h0000, REVISION});

    p_misc_zero_r3: assert property (@(posedge clk) disable iff (rst)
        (cfg_re && cfg_idx == IDX_W'(3)) |=> (cfg_rdata[7:0] == 8'h00 && cfg_rdata[31:16] == 16'h0000));

    p_iobase_low_r5: assert property (@(posedge clk) disable iff (rst)
        (cfg_re && cfg_idx == IDX_W'(4)) |=> cfg_rdata[7:0] == 8'h01);

    p_unimpl_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (cfg_re && !known_idx) |=> cfg_rdata == 32'h0);

    p_unimpl_nowrite_r8: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && !known_idx) |=> ($stable(lat_q) && $stable(iobase_word)));

    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !cfg_re |=> $stable(cfg_rdata));

    p_nobe_r10: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_be == 4'b0000) |=> ($stable(lat_q) && $stable(iobase_word)));
endmodule

bind netfn_cfg_hdr netfn_cfg_hdr_chk #(
    .IDX_W     (IDX_W),
    .VENDOR_ID (VENDOR_ID),
    .DEVICE_ID (DEVICE_ID),
    .REVISION  (REVISION)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cfg_idx     (cfg_idx),
    .cfg_be      (cfg_be),
    .cfg_we      (cfg_we),
    .cfg_re      (cfg_re),
    .cfg_rdata   (cfg_rdata),
    .lat_q       (lat_q),
    .iobase_word (iobase_word)
);

// File: tb/netfn_cfg_hdr_tb_top.sv
module netfn_cfg_hdr_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] VEN = 16'h1F3A;
    localparam logic [15:0] DEV = 16'h0C51;
    localparam logic [7:0]  REV = 8'h07;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  cfg_idx = '0;
    logic [3:0]  cfg_be = '0;
    logic [31:0] cfg_wdata = '0;
    logic        cfg_we = 1'b0;
    logic        cfg_re = 1'b0;
    logic [31:0] cfg_rdata;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Reference model state
    logic [7:0]  m_lat;
    logic [23:0] m_base;
    logic [31:0] m_rdata;

    always #(CLK_PERIOD/2) clk = ~clk;

    netfn_cfg_hdr dut_i (
        .clk       (clk),
        .rst       (rst),
        .cfg_idx   (cfg_idx),
        .cfg_be    (cfg_be),
        .cfg_wdata (cfg_wdata),
        .cfg_we    (cfg_we),
        .cfg_re    (cfg_re),
        .cfg_rdata (cfg_rdata)
    );

    function automatic logic [31:0] model_read(input logic [5:0] idx);
        case (idx)
            6'd0:    return {DEV, VEN};
            6'd2:    return {8'h02, 8'h00, 8'h00, REV};
            6'd3:    return {16'h0000, m_lat, 8'h00};
            6'd4:    return {m_base, 8'h01};
            default: return 32'h0;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    // One clock: drive, let the edge pass, advance the model, compare at the falling edge.
    task automatic step(input string req, input logic [5:0] idx, input logic [3:0] be,
                        input logic [31:0] wd, input logic we, input logic re);
        cfg_idx = idx; cfg_be = be; cfg_wdata = wd; cfg_we = we; cfg_re = re;
        @(posedge clk);
        if (re) m_rdata = model_read(idx);
        if (we && idx == 6'd3 && be[1]) m_lat = wd[15:8];
        if (we && idx == 6'd4) begin
            if (be[1]) m_base[7:0]   = wd[15:8];
            if (be[2]) m_base[15:8]  = wd[23:16];
            if (be[3]) m_base[23:16] = wd[31:24];
        end
        @(negedge clk);
        check(req, cfg_rdata, m_rdata);
    endtask

    task automatic rd(input string req, input logic [5:0] idx);
        step(req, idx, 4'h0, 32'h0, 1'b0, 1'b1);
    endtask

    task automatic wr(input string req, input logic [5:0] idx, input logic [3:0] be, input logic [31:0] wd);
        step(req, idx, be, wd, 1'b1, 1'b0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        m_lat = 8'h00; m_base = 24'h0; m_rdata = 32'h0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R6 rdata after reset", cfg_rdata, 32'h0);

        rd("R6 iobase reset", 6'd4);
        check("R6 iobase literal", cfg_rdata, 32'h0000_0001);
        rd("R6 latency reset", 6'd3);
        check("R6 latency literal", cfg_rdata, 32'h0);

        rd("R1 ident", 6'd0);
        check("R1 ident literal", cfg_rdata, {DEV, VEN});
        wr("R1 ident write", 6'd0, 4'hF, 32'hFFFF_FFFF);
        rd("R1 ident after write", 6'd0);

        rd("R2 class", 6'd2);
        check("R2 class literal", cfg_rdata, 32'h0200_0007);
        wr("R2 class write", 6'd2, 4'hF, 32'hA5A5_A5A5);
        rd("R2 class after write", 6'd2);

        wr("R3 R4 misc write all", 6'd3, 4'hF, 32'hFFFF_FFFF);
        rd("R3 R4 misc readback", 6'd3);
        check("R3 misc literal", cfg_rdata, 32'h0000_FF00);
        wr("R4 lane1 masked", 6'd3, 4'b1101, 32'h0000_0000);
        rd("R4 lat kept", 6'd3);
        wr("R4 lane1 only", 6'd3, 4'b0010, 32'h1234_5678);
        rd("R4 lat 56", 6'd3);
        check("R4 lat literal", cfg_rdata, 32'h0000_5600);

        wr("R7 sizing write", 6'd4, 4'hF, 32'hFFFF_FFFF);
        rd("R7 sizing read", 6'd4);
        check("R7 sizing literal", cfg_rdata, 32'hFFFF_FF01);
        wr("R10 no enables iobase", 6'd4, 4'h0, 32'h0);
        wr("R10 no enables misc", 6'd3, 4'h0, 32'h0);
        rd("R10 iobase kept", 6'd4);
        rd("R10 lat kept", 6'd3);
        wr("R5 lane2 clear", 6'd4, 4'b0100, 32'h0);
        rd("R5 lane2 read", 6'd4);
        check("R5 lane2 literal", cfg_rdata, 32'hFF00_FF01);
        wr("R5 lane0 ignored", 6'd4, 4'b0001, 32'h0);
        rd("R5 lane0 read", 6'd4);

        step("R9 read with write iobase", 6'd4, 4'hF, 32'h1234_5678, 1'b1, 1'b1);
        check("R9 old value literal", cfg_rdata, 32'hFF00_FF01);
        rd("R9 new iobase", 6'd4);
        check("R5 R9 new literal", cfg_rdata, 32'h1234_5601);
        step("R9 read with write lat", 6'd3, 4'b0010, 32'h0000_9900, 1'b1, 1'b1);
        step("R9 hold no read", 6'd0, 4'h0, 32'h0, 1'b0, 1'b0);
        step("R9 hold no read 2", 6'd2, 4'hF, 32'h0, 1'b1, 1'b0);
        rd("R9 lat new", 6'd3);

        wr("R8 write idx1", 6'd1, 4'hF, 32'hFFFF_FFFF);
        wr("R8 write idx5", 6'd5, 4'hF, 32'hFFFF_FFFF);
        wr("R8 write idx63", 6'd63, 4'hF, 32'hFFFF_FFFF);
        rd("R8 read idx1", 6'd1);
        rd("R8 read idx5", 6'd5);
        rd("R8 read idx63", 6'd63);
        check("R8 literal", cfg_rdata, 32'h0);
        rd("R8 iobase intact", 6'd4);
        rd("R8 lat intact", 6'd3);

        for (int n = 0; n < 400; n++) begin
            logic [5:0] ix;
            ix = ($urandom % 4 == 0) ? 6'($urandom) : 6'($urandom % 6);
            step("R4 R5 R9 mixed", ix, 4'($urandom), $urandom, 1'($urandom), 1'($urandom));
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule